// File: doc/BRIEF.md
# Lane-Banked Dual-Port RAM with Selectable Port Widths

This block is a synchronous RAM with two independent ports that share one storage array. The array is built from 9-bit lanes, eight lanes to a 72-bit row. Each port is set by parameter to 1, 2, 4 or 8 lanes (9, 18, 36 or 72 bits). A narrow port addresses individual lane groups inside a row, so the same storage can be seen as 8·ROWS words of 9 bits on one side and ROWS words of 72 bits on the other. A separate 144-bit mode joins the two ports into one wide write path and one wide read path.

Each port has a single write-enable that sets its mode for the cycle. High means a write and low means a read. No read-enable exists, and the output register loads every cycle. Writes are masked per lane by a byte-enable vector of one bit per lane. Both ports run on one shared clock. Reads have one registered stage and return the contents as they were before the edge's writes.

Top module: `lanebank_dpram`

## Requirements
- R1: `dout` of a port holds the word stored at the address sampled on the previous rising edge. The output register loads on every cycle whatever the value of `we`.
- R2: With `we` high and all enables set, the port's whole word at `addr` takes `din` on the edge. With `we` low nothing is written. No read-enable input exists.
- R3: In 18-, 36- and 72-bit widths, enable bit k governs data bits [9k+8:9k]. A lane whose enable is low keeps its earlier contents.
- R4: A 9-bit port writes on `we` alone. Its single enable bit has no effect.
- R5: A port of L lanes maps word `addr` onto global lanes addr·L to addr·L+L-1. Global lane n lies in row n/8 at lane n mod 8. The low address bits of a narrow port pick the lane group within a row, lowest first.
- R6: A read on the same edge as a write to the same lanes returns the old contents. This holds for the writing port and for the other port.
- R7: With SIMPLE144=1, port A writes 144 bits from `din_a` (two rows, rows 2a and 2a+1). The 16-lane mask is {`be_b`,`be_a``}, with `be_a` covering lanes 0–7. Port B reads 144 bits on `dout_b`. `we_b` and `din_b` are ignored, and `dout_a` stays zero.
- R8: A synchronous active-high reset clears both outputs to zero on the next edge. It leaves the stored data unchanged.
- R9: Both ports may write disjoint lanes in one cycle, in the same row, and both writes land. A write by both ports to the same lane in one cycle is illegal and has an undefined result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| rst | input | 1 | Synchronous active-high reset of the output registers |
| we_a | input | 1 | Port A write (1) or read (0) |
| addr_a | input | AWA | Port A word address |
| be_a | input | BEA | Port A lane enables (LANES_A bits, 8 in 144-bit mode) |
| din_a | input | 9·LA | Port A write data (144 bits in 144-bit mode) |
| dout_a | output | 9·LA | Port A registered read data (zero in 144-bit mode) |
| we_b | input | 1 | Port B write (1) or read (0), ignored in 144-bit mode |
| addr_b | input | AWB | Port B word address |
| be_b | input | BEB | Port B lane enables, upper half of the mask in 144-bit mode |
| din_b | input | 9·LB | Port B write data, ignored in 144-bit mode |
| dout_b | output | 9·LB | Port B registered read data |

## Verification
The bench runs five instances at once that cover all four widths on each port and the 144-bit mode. It checks every read against a shadow array after full fills, exhaustive address sweeps and random masked traffic. The sweeps catch a swapped or big-endian lane-group mapping, which would return a neighbour's lanes on the narrow side. Same-edge write and read cases expose a write-first array, which would show new data one cycle early. Writes from both ports into one row expose a bank that lets one port's write drop the other's. Masked-off lanes in random traffic and zero enables on 9-bit ports catch a mask applied at the wrong lane or applied where it must be ignored. A reset in mid-run catches output registers that fail to clear and storage that is wrongly wiped.

// File: rtl/lanebank_pkg.sv
package lanebank_pkg;

    localparam int LANE_W    = 9;
    localparam int ROW_LANES = 8;
    localparam int WIDE_LANES = 16;

    typedef struct packed {
        logic              en;
        logic [LANE_W-1:0] data;
    } lane_wr_t;

    // lanes a port spans once the wide mode is taken into account
    function automatic int port_lanes(int lanes, int wide);
        return (wide != 0) ? WIDE_LANES : lanes;
    endfunction

    // number of lane banks: one row of banks holds the widest word
    function automatic int bank_count(int wide);
        return (wide != 0) ? WIDE_LANES : ROW_LANES;
    endfunction

    // enable vector width seen at a port
    function automatic int enable_width(int lanes, int wide);
        return (wide != 0) ? ROW_LANES : lanes;
    endfunction

    // bits needed to name a lane group inside one bank row (at least one)
    function automatic int group_bits(int banks, int lanes);
        return (banks / lanes > 1) ? $clog2(banks / lanes) : 1;
    endfunction

endpackage

// File: rtl/lb_port_map.sv
module lb_port_map
    import lanebank_pkg::*;
#(
    parameter int L  = 1,
    parameter int NB = 8,
    parameter int AW = 9,
    parameter int RW = 6,
    parameter int GW = 3
) (
    input  logic                  we,
    input  logic [AW-1:0]         addr,
    input  logic [L-1:0]          be,
    input  logic [L*LANE_W-1:0]   din,
    output lane_wr_t              wr [NB],
    output logic [RW-1:0]         row,
    output logic [GW-1:0]         grp
);
    localparam int GPW = NB / L;
    localparam int GB  = $clog2(GPW);

    generate
        if (GB > 0) begin : g_split
            assign grp = GW'(addr[GB-1:0]);
            assign row = addr[AW-1:GB];
        end else begin : g_whole
            assign grp = '0;
            assign row = addr;
        end

        for (genvar j = 0; j < NB; j++) begin : g_bank
            localparam int K = j % L;
            localparam int G = j / L;
            logic hit;
            logic lane_on;
            assign hit = (grp == GW'(G));
            if (L == 1) begin : g_nomask
                assign lane_on = 1'b1;
            end else begin : g_mask
                assign lane_on = be[K];
            end
            assign wr[j].en   = we & hit & lane_on;
            assign wr[j].data = din[K*LANE_W +: LANE_W];
        end
    endgenerate
endmodule

// File: rtl/lb_bank.sv
module lb_bank
    import lanebank_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int RW    = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  lane_wr_t          wa,
    input  logic [RW-1:0]     ra,
    input  lane_wr_t          wb,
    input  logic [RW-1:0]     rb,
    output logic [LANE_W-1:0] qa,
    output logic [LANE_W-1:0] qb
);
    logic [LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wb.en) mem[rb] <= wb.data;
        if (wa.en) mem[ra] <= wa.data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            qa <= '0;
            qb <= '0;
        end else begin
            qa <= mem[ra];
            qb <= mem[rb];
        end
    end
endmodule

// File: rtl/lb_read_sel.sv
module lb_read_sel
    import lanebank_pkg::*;
#(
    parameter int L  = 1,
    parameter int NB = 8,
    parameter int GW = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [GW-1:0]       grp,
    input  logic [LANE_W-1:0]   q [NB],
    output logic [L*LANE_W-1:0] dout
);
    localparam int GPW = NB / L;

    logic [GW-1:0] grp_q;

    always_ff @(posedge clk) begin
        if (rst) grp_q <= '0;
        else     grp_q <= grp;
    end

    generate
        for (genvar k = 0; k < L; k++) begin : g_lane
            logic [LANE_W-1:0] pick;
            always_comb begin
                pick = '0;
                for (int g = 0; g < GPW; g++) begin
                    if (grp_q == GW'(g)) pick = q[g*L + k];
                end
            end
            assign dout[k*LANE_W +: LANE_W] = pick;
        end
    endgenerate
endmodule

// File: rtl/lanebank_dpram.sv
module lanebank_dpram
    import lanebank_pkg::*;
#(
    parameter int ROWS      = 64,
    parameter int LANES_A   = 1,
    parameter int LANES_B   = 8,
    parameter int SIMPLE144 = 0,
    localparam int LA   = port_lanes(LANES_A, SIMPLE144),
    localparam int LB   = port_lanes(LANES_B, SIMPLE144),
    localparam int AWA  = $clog2(ROWS * ROW_LANES / LA),
    localparam int AWB  = $clog2(ROWS * ROW_LANES / LB),
    localparam int BEA  = enable_width(LANES_A, SIMPLE144),
    localparam int BEB  = enable_width(LANES_B, SIMPLE144),
    localparam int DWA  = LANE_W * LA,
    localparam int DWB  = LANE_W * LB
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           we_a,
    input  logic [AWA-1:0] addr_a,
    input  logic [BEA-1:0] be_a,
    input  logic [DWA-1:0] din_a,
    output logic [DWA-1:0] dout_a,
    input  logic           we_b,
    input  logic [AWB-1:0] addr_b,
    input  logic [BEB-1:0] be_b,
    input  logic [DWB-1:0] din_b,
    output logic [DWB-1:0] dout_b
);
    localparam int NB    = bank_count(SIMPLE144);
    localparam int DEPTH = ROWS * ROW_LANES / NB;
    localparam int RW    = $clog2(DEPTH);
    localparam int GWA   = group_bits(NB, LA);
    localparam int GWB   = group_bits(NB, LB);

    lane_wr_t          wr_a [NB];
    lane_wr_t          wr_b [NB];
    logic [RW-1:0]     row_a, row_b;
    logic [GWA-1:0]    grp_a;
    logic [GWB-1:0]    grp_b;
    logic [LANE_W-1:0] q_a [NB];
    logic [LANE_W-1:0] q_b [NB];
    logic [LA-1:0]     mask_a;
    logic [LB-1:0]     mask_b;
    logic              wen_b;
    logic [DWA-1:0]    rd_a;

    generate
        if (SIMPLE144 != 0) begin : g_wide
            assign mask_a = {be_b, be_a};
            assign mask_b = '1;
            assign wen_b  = we_b & 1'b0;
        end else begin : g_dual
            assign mask_a = be_a;
            assign mask_b = be_b;
            assign wen_b  = we_b;
        end
    endgenerate

    lb_port_map #(.L(LA), .NB(NB), .AW(AWA), .RW(RW), .GW(GWA)) u_map_a (
        .we(we_a), .addr(addr_a), .be(mask_a), .din(din_a),
        .wr(wr_a), .row(row_a), .grp(grp_a)
    );

    lb_port_map #(.L(LB), .NB(NB), .AW(AWB), .RW(RW), .GW(GWB)) u_map_b (
        .we(wen_b), .addr(addr_b), .be(mask_b), .din(din_b),
        .wr(wr_b), .row(row_b), .grp(grp_b)
    );

    generate
        for (genvar j = 0; j < NB; j++) begin : g_lane_bank
            lb_bank #(.DEPTH(DEPTH), .RW(RW)) u_bank (
                .clk(clk), .rst(rst),
                .wa(wr_a[j]), .ra(row_a),
                .wb(wr_b[j]), .rb(row_b),
                .qa(q_a[j]), .qb(q_b[j])
            );
        end
    endgenerate

    lb_read_sel #(.L(LA), .NB(NB), .GW(GWA)) u_sel_a (
        .clk(clk), .rst(rst), .grp(grp_a), .q(q_a), .dout(rd_a)
    );

    lb_read_sel #(.L(LB), .NB(NB), .GW(GWB)) u_sel_b (
        .clk(clk), .rst(rst), .grp(grp_b), .q(q_b), .dout(dout_b)
    );

    assign dout_a = (SIMPLE144 != 0) ? '0 : rd_a;
endmodule

// File: rtl/lanebank_dpram_chk.sv
module lanebank_dpram_chk
    import lanebank_pkg::*;
#(
    parameter int ROWS      = 64,
    parameter int LANES_A   = 1,
    parameter int LANES_B   = 8,
    parameter int SIMPLE144 = 0,
    localparam int LA  = port_lanes(LANES_A, SIMPLE144),
    localparam int LB  = port_lanes(LANES_B, SIMPLE144),
    localparam int AWA = $clog2(ROWS * ROW_LANES / LA),
    localparam int AWB = $clog2(ROWS * ROW_LANES / LB),
    localparam int BEA = enable_width(LANES_A, SIMPLE144),
    localparam int BEB = enable_width(LANES_B, SIMPLE144),
    localparam int DWA = LANE_W * LA,
    localparam int DWB = LANE_W * LB
) (
    input logic           clk,
    input logic           rst,
    input logic           we_a,
    input logic [AWA-1:0] addr_a,
    input logic [BEA-1:0] be_a,
    input logic [DWA-1:0] din_a,
    input logic [DWA-1:0] dout_a,
    input logic           we_b,
    input logic [AWB-1:0] addr_b,
    input logic [BEB-1:0] be_b,
    input logic [DWB-1:0] dout_b
);
    logic clash;

    generate
        if (SIMPLE144 == 0) begin : g_dual
            logic full_a;
            assign full_a = (LA == 1) ? 1'b1 : (&be_a);

            always_comb begin
                clash = 1'b0;
                if (we_a && we_b) begin
                    for (int k = 0; k < LA; k++) begin
                        for (int m = 0; m < LB; m++) begin
                            if ((int'(addr_a) * LA + k == int'(addr_b) * LB + m) &&
                                (LA == 1 || be_a[k]) && (LB == 1 || be_b[m]))
                                clash = 1'b1;
                        end
                    end
                end
            end

            // R9
            no_lane_clash_chk: assert property (@(posedge clk) disable iff (rst)
                !clash);

            // R2
            write_readback_a_chk: assert property (@(posedge clk) disable iff (rst)
                (we_a && full_a) ##1 (!we_a && !we_b && addr_a == $past(addr_a))
                |=> (dout_a == $past(din_a, 2)));

            // R1
            hold_read_a_chk: assert property (@(posedge clk) disable iff (rst)
                (!$past(rst) && addr_a == $past(addr_a) && !$past(we_a) && !$past(we_b))
                |=> $stable(dout_a));

            // R1
            hold_read_b_chk: assert property (@(posedge clk) disable iff (rst)
                (!$past(rst) && addr_b == $past(addr_b) && !$past(we_a) && !$past(we_b))
                |=> $stable(dout_b));
        end else begin : g_wide
            assign clash = 1'b0;

            // R7
            wide_readback_chk: assert property (@(posedge clk) disable iff (rst)
                (we_a && (&{be_b, be_a})) ##1 (!we_a && addr_b == $past(addr_a))
                |=> (dout_b == $past(din_a, 2)));

            // R7
            wide_hold_b_chk: assert property (@(posedge clk) disable iff (rst)
                (!$past(rst) && addr_b == $past(addr_b) && !$past(we_a))
                |=> $stable(dout_b));
        end
    endgenerate

    // R8
    reset_outputs_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (dout_a == '0 && dout_b == '0));
endmodule

bind lanebank_dpram lanebank_dpram_chk #(
    .ROWS(ROWS), .LANES_A(LANES_A), .LANES_B(LANES_B), .SIMPLE144(SIMPLE144)
) u_chk (
    .clk(clk), .rst(rst),
    .we_a(we_a), .addr_a(addr_a), .be_a(be_a), .din_a(din_a), .dout_a(dout_a),
    .we_b(we_b), .addr_b(addr_b), .be_b(be_b), .dout_b(dout_b)
);

// File: tb/sim_lanebank_dpram.sv
module sim_lanebank_dpram;
    localparam int CLK_PERIOD = 10;
    localparam int ROWS = 64;
    localparam int TOT  = ROWS * 8;
    localparam int NI   = 5;

    function automatic int la(int i);
        case (i) 0: return 1; 1: return 2; 2: return 4; 3: return 8; default: return 16; endcase
    endfunction
    function automatic int lb(int i);
        case (i) 0: return 8; 1: return 4; 2: return 2; 3: return 1; default: return 16; endcase
    endfunction
    function automatic bit wide(int i);
        return i == 4;
    endfunction

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic [143:0] dinA [NI];
    logic [143:0] dinB [NI];
    logic [15:0]  adA  [NI];
    logic [15:0]  adB  [NI];
    logic [7:0]   beA  [NI];
    logic [7:0]   beB  [NI];
    logic         weA  [NI];
    logic         weB  [NI];
    wire  [143:0] qA   [NI];
    wire  [143:0] qB   [NI];

    lanebank_dpram #(.ROWS(ROWS), .LANES_A(1), .LANES_B(8)) u0 (
        .clk(clk), .rst(rst),
        .we_a(weA[0]), .addr_a(adA[0][8:0]), .be_a(beA[0][0:0]), .din_a(dinA[0][8:0]), .dout_a(qA[0][8:0]),
        .we_b(weB[0]), .addr_b(adB[0][5:0]), .be_b(beB[0][7:0]), .din_b(dinB[0][71:0]), .dout_b(qB[0][71:0]));
    lanebank_dpram #(.ROWS(ROWS), .LANES_A(2), .LANES_B(4)) u1 (
        .clk(clk), .rst(rst),
        .we_a(weA[1]), .addr_a(adA[1][7:0]), .be_a(beA[1][1:0]), .din_a(dinA[1][17:0]), .dout_a(qA[1][17:0]),
        .we_b(weB[1]), .addr_b(adB[1][6:0]), .be_b(beB[1][3:0]), .din_b(dinB[1][35:0]), .dout_b(qB[1][35:0]));
    lanebank_dpram #(.ROWS(ROWS), .LANES_A(4), .LANES_B(2)) u2 (
        .clk(clk), .rst(rst),
        .we_a(weA[2]), .addr_a(adA[2][6:0]), .be_a(beA[2][3:0]), .din_a(dinA[2][35:0]), .dout_a(qA[2][35:0]),
        .we_b(weB[2]), .addr_b(adB[2][7:0]), .be_b(beB[2][1:0]), .din_b(dinB[2][17:0]), .dout_b(qB[2][17:0]));
    lanebank_dpram #(.ROWS(ROWS), .LANES_A(8), .LANES_B(1)) u3 (
        .clk(clk), .rst(rst),
        .we_a(weA[3]), .addr_a(adA[3][5:0]), .be_a(beA[3][7:0]), .din_a(dinA[3][71:0]), .dout_a(qA[3][71:0]),
        .we_b(weB[3]), .addr_b(adB[3][8:0]), .be_b(beB[3][0:0]), .din_b(dinB[3][8:0]), .dout_b(qB[3][8:0]));
    lanebank_dpram #(.ROWS(ROWS), .LANES_A(8), .LANES_B(8), .SIMPLE144(1)) u4 (
        .clk(clk), .rst(rst),
        .we_a(weA[4]), .addr_a(adA[4][4:0]), .be_a(beA[4]), .din_a(dinA[4]), .dout_a(qA[4]),
        .we_b(weB[4]), .addr_b(adB[4][4:0]), .be_b(beB[4]), .din_b(dinB[4]), .dout_b(qB[4]));

    logic [8:0]   sh   [NI][TOT];
    logic [143:0] expA [NI];
    logic [143:0] expB [NI];
    bit    chk_on = 0;
    bit    done = 0;
    string tag = "R8";
    int    errs = 0;
    int    checks = 0;

    function automatic logic [143:0] rnd144();
        logic [159:0] r;
        r = {$urandom, $urandom, $urandom, $urandom, $urandom};
        return r[143:0];
    endfunction

    function automatic logic [143:0] gather(int i, int ad, int L);
        logic [143:0] r = '0;
        for (int k = 0; k < L; k++) r[k*9 +: 9] = sh[i][ad*L + k];
        return r;
    endfunction

    function automatic logic [143:0] wmask(int L);
        return {144{1'b1}} >> (144 - 9*L);
    endfunction

    task automatic idle();
        for (int i = 0; i < NI; i++) begin
            weA[i] = 0; weB[i] = 0; beA[i] = 8'hFF; beB[i] = 8'hFF;
        end
    endtask

    task automatic check_outputs();
        for (int i = 0; i < NI; i++) begin
            logic [143:0] mA, mB;
            mA = wmask(la(i));
            mB = wmask(lb(i));
            checks++;
            if ((qA[i] & mA) !== (expA[i] & mA)) begin
                errs++;
                $display("FAIL %s u%0d dout_a got %h expected %h", tag, i, qA[i] & mA, expA[i] & mA);
            end
            checks++;
            if ((qB[i] & mB) !== (expB[i] & mB)) begin
                errs++;
                $display("FAIL %s u%0d dout_b got %h expected %h", tag, i, qB[i] & mB, expB[i] & mB);
            end
        end
    endtask

    // inputs are already set; model one edge, then compare at the next falling edge
    task automatic cyc();
        for (int i = 0; i < NI; i++) begin
            if (rst) begin
                expA[i] = '0;
                expB[i] = '0;
            end else begin
                expA[i] = wide(i) ? '0 : gather(i, int'(adA[i]), la(i));
                expB[i] = gather(i, int'(adB[i]), lb(i));
            end
            if (weA[i]) begin
                for (int k = 0; k < la(i); k++) begin
                    bit en;
                    if (la(i) == 1) en = 1;
                    else if (wide(i)) en = (k < 8) ? beA[i][k] : beB[i][k-8];
                    else en = beA[i][k];
                    if (en) sh[i][int'(adA[i])*la(i) + k] = dinA[i][k*9 +: 9];
                end
            end
            if (weB[i] && !wide(i)) begin
                for (int m = 0; m < lb(i); m++) begin
                    if (lb(i) == 1 || beB[i][m])
                        sh[i][int'(adB[i])*lb(i) + m] = dinB[i][m*9 +: 9];
                end
            end
        end
        @(negedge clk);
        if (chk_on) check_outputs();
    endtask

    task automatic sweep(string t);
        tag = t;
        idle();
        for (int s = 0; s < TOT; s++) begin
            for (int i = 0; i < NI; i++) begin
                adA[i] = 16'(s % (TOT / la(i)));
                adB[i] = 16'((s * 7 + 3) % (TOT / lb(i)));
            end
            cyc();
        end
    endtask

    initial begin
        for (int i = 0; i < NI; i++) begin
            adA[i] = '0; adB[i] = '0; dinA[i] = '0; dinB[i] = '0;
            for (int n = 0; n < TOT; n++) sh[i][n] = '0;
        end
        idle();
        @(negedge clk);

        // R8: outputs cleared while reset is held
        chk_on = 1;
        tag = "R8";
        repeat (3) cyc();
        rst = 0;

        // R2: fill every word through port A, unchecked (old contents unknown)
        chk_on = 0;
        for (int s = 0; s < TOT; s++) begin
            for (int i = 0; i < NI; i++) begin
                weA[i] = 1; weB[i] = 0; beA[i] = 8'hFF; beB[i] = 8'hFF;
                adA[i] = 16'(s % (TOT / la(i)));
                dinA[i] = rnd144();
            end
            cyc();
        end
        chk_on = 1;

        // R1 R2 R5: exhaustive read sweep across mismatched widths
        sweep("R1/R2/R5");

        // R6: write on A while B reads the same lanes on the same edge
        tag = "R6";
        for (int c = 0; c < 8; c++) begin
            for (int i = 0; i < NI; i++) begin
                weA[i] = 1; weB[i] = 0; beA[i] = 8'hFF; beB[i] = 8'hFF;
                adA[i] = 16'(c);
                adB[i] = wide(i) ? 16'(c) : 16'((c * la(i)) / lb(i));
                dinA[i] = rnd144();
            end
            cyc();
        end
        idle();
        cyc();

        // R4: 9-bit ports write with their enable held low
        tag = "R4";
        for (int c = 0; c < 8; c++) begin
            idle();
            weA[0] = 1; beA[0] = 8'h00; adA[0] = 16'(40 + c); dinA[0] = rnd144();
            weB[3] = 1; beB[3] = 8'h00; adB[3] = 16'(200 + c); dinB[3] = rnd144();
            cyc();
        end
        idle();
        for (int c = 0; c < 8; c++) begin
            adA[0] = 16'(40 + c); adB[3] = 16'(200 + c);
            cyc();
        end

        // R9: both ports write disjoint lanes of row 0 on one edge
        tag = "R9";
        idle();
        for (int i = 0; i < 4; i++) begin
            weA[i] = 1; weB[i] = 1;
            adA[i] = 0; adB[i] = 16'(8 / lb(i) - 1);
            dinA[i] = rnd144(); dinB[i] = rnd144();
            if (lb(i) == 1) beA[i][7] = 1'b0;
            else for (int m = 0; m < lb(i); m++) if (8 - lb(i) + m < la(i)) beB[i][m] = 1'b0;
        end
        cyc();
        idle();
        cyc();
        cyc();

        // R3 R4 R6 R7: random masked traffic, both ports, no lane clashes
        tag = "R3/R4/R6/R7";
        for (int c = 0; c < 1500; c++) begin
            for (int i = 0; i < NI; i++) begin
                int wa, wb;
                wa = TOT / la(i);
                wb = TOT / lb(i);
                weA[i] = $urandom_range(0, 1) == 1;
                weB[i] = $urandom_range(0, 1) == 1;
                beA[i] = 8'($urandom);
                beB[i] = 8'($urandom);
                dinA[i] = rnd144();
                dinB[i] = rnd144();
                if (!wide(i) && weA[i] && weB[i]) begin
                    adA[i] = 16'($urandom_range(0, wa/2 - 1));
                    adB[i] = 16'(wb/2 + $urandom_range(0, wb/2 - 1));
                end else begin
                    adA[i] = 16'($urandom_range(0, wa - 1));
                    adB[i] = 16'($urandom_range(0, wb - 1));
                end
            end
            cyc();
        end

        // R3: every lane outcome of the random traffic read back
        sweep("R3/R5");

        // R8: reset mid-run clears outputs only; contents survive
        tag = "R8";
        idle();
        rst = 1;
        cyc();
        rst = 0;
        sweep("R8");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errs++;
            checks++;
            $display("FAIL watchdog: run did not finish, got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end
endmodule